// File: doc/BRIEF.md
# Multi-Line Atomic Event Tracker

This block sits next to a core's load/store pipeline and supervises an atomic event that spans several cache lines. The core first marks a recovery point. It then registers each line it intends to modify with a locked load or a locked prefetch. During this touch phase the block records each distinct line address in a participant slot. When a touch finds the line absent, or present without write permission, the block asks the memory side for the line with intent to modify, and it holds off further requests until that request is answered.

Once the core issues its first ordinary store, the event is in its write phase. Each store to a registered line is held as a tentative write in that line's slot. A locked store is the final access of the event. If no other agent has snooped a participating line, all tentative writes are presented together on the commit bus in a single cycle. If a participating line was snooped, the writes are dropped and the core is sent back to its recovery point. Software may also poll the interference flag before its first store, so that it gets control at a point it chose. Ordering and count violations end the event with an operation fault. Every outcome empties all slots in one cycle.

Top module: `atm_event_tracker`

## Requirements
- R1: After reset, `evt_active`, `end_valid`, `commit_valid`, `poll_valid`, `miss_req_valid` and `intf_flag` are 0 and `req_ready` is 1. An accepted begin request (`req_op`=1) while idle sets `evt_active` on the next cycle and records `req_addr` as the recovery point.
- R2: A locked load (`req_op`=2) or locked prefetch (`req_op`=3) in the touch phase registers the line `req_addr[ADDR_W-1:LINE_OFS]`. Slots are filled in order, with slot 0 first.
- R3: At most MAX_PART distinct lines (8 by default) can take part. A repeated touch of a line already registered takes no new slot.
- R4: A touch of a new line when all MAX_PART slots are full ends the event on the next cycle with `end_valid`=1 and `end_code`=2 (fault).
- R5: A store (`req_op`=4 or 5) whose line is not registered, or any touch after the first ordinary store, ends the event with `end_code`=2.
- R6: A touch accepted while `lookup_hit`&`lookup_wperm` is 0 raises `miss_req_valid` on the next cycle, with `miss_req_line` equal to the touched line. `req_ready` stays 0 until the cycle after `miss_resp_valid`.
- R7: An ordinary store (`req_op`=4) to a registered line puts its address and data into that line's slot, replacing any earlier store to that line. It produces no commit output.
- R8: A locked store (`req_op`=5) to a registered line with no interference gives, on the next cycle, `end_valid`=1, `end_code`=0 and `commit_valid`=1. `commit_mask` bit i is set for every slot that holds a write. Slot i's address and data appear at `commit_addr[i*ADDR_W+:ADDR_W]` and `commit_data[i*DATA_W+:DATA_W]`, and unmasked slices are 0.
- R9: A snoop whose line matches a registered line sets `intf_flag`. A later locked store then ends the event with `end_code`=1, `commit_valid`=0 and `redirect_pc` equal to the recovery point.
- R10: A snoop of an unregistered line, or any snoop while idle, leaves `intf_flag` at 0 and has no effect on the outcome.
- R11: A poll (`req_op`=6) in the touch phase gives `poll_valid`=1 on the next cycle, with `poll_flag` showing interference. If that flag is 1, the event ends with `end_code`=3 and no redirect. A poll after the first store ends the event with `end_code`=2.
- R12: The cycle after any end, `evt_active` is 0 and every slot is empty, so the next event can again register MAX_PART lines.
- R13: Requests other than begin are ignored while idle, and begin is ignored while an event is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_op | input | 3 | 1 begin, 2 locked load, 3 locked prefetch, 4 store, 5 locked store, 6 poll |
| req_addr | input | ADDR_W | Byte address (recovery point for begin) |
| req_wdata | input | DATA_W | Store data |
| lookup_hit | input | 1 | Cache holds the touched line |
| lookup_wperm | input | 1 | Cache holds the touched line writable |
| miss_req_valid | output | 1 | Read-with-intent-to-modify request pending |
| miss_req_line | output | ADDR_W-LINE_OFS | Line requested |
| miss_resp_valid | input | 1 | Requested line granted |
| snoop_valid | input | 1 | Another agent accesses a line |
| snoop_line | input | ADDR_W-LINE_OFS | Snooped line address |
| evt_active | output | 1 | Event in progress |
| intf_flag | output | 1 | Interference seen in current event |
| poll_valid | output | 1 | Poll answer valid |
| poll_flag | output | 1 | Poll answer |
| end_valid | output | 1 | Event ended last cycle |
| end_code | output | 2 | 0 commit, 1 retry, 2 fault, 3 polled failure |
| redirect_pc | output | ADDR_W | Recovery point on retry |
| commit_valid | output | 1 | Tentative writes become visible |
| commit_mask | output | MAX_PART | Slots carrying a write |
| commit_addr | output | MAX_PART*ADDR_W | Per-slot write address |
| commit_data | output | MAX_PART*DATA_W | Per-slot write data |

## Verification
The bench uses the default parameters: eight slots, 64-byte lines, and 32-bit addresses and data. Random addresses come from a pool of twelve lines. That pool is larger than the slot count, so a ninth-line fault, a repeated touch of a registered line, snoops that hit, and snoops that miss all occur many times within a few thousand requests. The lookup inputs are randomised as well, so fill stalls show up in both the touch and repeat-touch cases.

// File: rtl/atm_pkg.sv
package atm_pkg;
    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_BEGIN = 3'd1,
        OP_LDL   = 3'd2,
        OP_PFL   = 3'd3,
        OP_ST    = 3'd4,
        OP_STL   = 3'd5,
        OP_POLL  = 3'd6
    } atm_op_e;

    typedef enum logic [1:0] {
        END_COMMIT = 2'd0,
        END_RETRY  = 2'd1,
        END_FAULT  = 2'd2,
        END_POLLED = 2'd3
    } atm_end_e;
endpackage

// File: rtl/atm_line_cam.sv
module atm_line_cam #(
    parameter int N      = 8,
    parameter int LINE_W = 26,
    parameter int IDX_W  = 3
) (
    input  logic [N-1:0]             vmask,
    input  logic [N-1:0][LINE_W-1:0] lines,
    input  logic [LINE_W-1:0]        key_a,
    input  logic [LINE_W-1:0]        key_b,
    output logic [N-1:0]             match_a,
    output logic                     hit_a,
    output logic [IDX_W-1:0]         idx_a,
    output logic                     hit_b
);
    logic [N-1:0] match_b;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match_a[i] = vmask[i] && (lines[i] == key_a);
        assign match_b[i] = vmask[i] && (lines[i] == key_b);
    end

    assign hit_a = |match_a;
    assign hit_b = |match_b;

    always_comb begin
        idx_a = '0;
        for (int i = 0; i < N; i++) begin
            if (match_a[i]) idx_a = IDX_W'(i);
        end
    end
endmodule

// File: rtl/atm_commit_pack.sv
module atm_commit_pack #(
    parameter int N      = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic [N-1:0]             mask,
    input  logic [N-1:0][ADDR_W-1:0] addrs,
    input  logic [N-1:0][DATA_W-1:0] datas,
    output logic [N*ADDR_W-1:0]      addr_flat,
    output logic [N*DATA_W-1:0]      data_flat
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        assign addr_flat[i*ADDR_W +: ADDR_W] = mask[i] ? addrs[i] : '0;
        assign data_flat[i*DATA_W +: DATA_W] = mask[i] ? datas[i] : '0;
    end
endmodule

// File: rtl/atm_event_tracker.sv
module atm_event_tracker
    import atm_pkg::*;
#(
    parameter int MAX_PART = 8,
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int LINE_OFS = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [2:0]                   req_op,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W-1:0]            req_wdata,
    input  logic                         lookup_hit,
    input  logic                         lookup_wperm,
    output logic                         miss_req_valid,
    output logic [ADDR_W-LINE_OFS-1:0]   miss_req_line,
    input  logic                         miss_resp_valid,
    input  logic                         snoop_valid,
    input  logic [ADDR_W-LINE_OFS-1:0]   snoop_line,
    output logic                         evt_active,
    output logic                         intf_flag,
    output logic                         poll_valid,
    output logic                         poll_flag,
    output logic                         end_valid,
    output logic [1:0]                   end_code,
    output logic [ADDR_W-1:0]            redirect_pc,
    output logic                         commit_valid,
    output logic [MAX_PART-1:0]          commit_mask,
    output logic [MAX_PART*ADDR_W-1:0]   commit_addr,
    output logic [MAX_PART*DATA_W-1:0]   commit_data
);
    localparam int LINE_W = ADDR_W - LINE_OFS;
    localparam int IDX_W  = (MAX_PART > 1) ? $clog2(MAX_PART) : 1;
    localparam int CNT_W  = $clog2(MAX_PART + 1);

    typedef struct packed {
        logic                               active;
        logic                               wphase;
        logic                               intf;
        logic                               pend;
        logic [CNT_W-1:0]                   cnt;
        logic [MAX_PART-1:0]                vmask;
        logic [MAX_PART-1:0]                dirty;
        logic [MAX_PART-1:0][LINE_W-1:0]    line;
        logic [MAX_PART-1:0][ADDR_W-1:0]    waddr;
        logic [MAX_PART-1:0][DATA_W-1:0]    wdata;
        logic [ADDR_W-1:0]                  rp;
        logic [LINE_W-1:0]                  pend_line;
        logic                               end_v;
        logic [1:0]                         end_code;
        logic                               commit_v;
        logic [MAX_PART-1:0]                cmask;
        logic [ADDR_W-1:0]                  redir;
        logic                               poll_v;
        logic                               poll_flag;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic [LINE_W-1:0]   req_line;
    logic [MAX_PART-1:0] cam_match;
    logic                cam_hit;
    logic [IDX_W-1:0]    cam_idx;
    logic                snp_hit_raw;

    assign req_line = req_addr[ADDR_W-1:LINE_OFS];

    atm_line_cam #(
        .N      (MAX_PART),
        .LINE_W (LINE_W),
        .IDX_W  (IDX_W)
    ) u_cam (
        .vmask   (st_q.vmask),
        .lines   (st_q.line),
        .key_a   (req_line),
        .key_b   (snoop_line),
        .match_a (cam_match),
        .hit_a   (cam_hit),
        .idx_a   (cam_idx),
        .hit_b   (snp_hit_raw)
    );

    atm_commit_pack #(
        .N      (MAX_PART),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pack (
        .mask      (st_q.cmask),
        .addrs     (st_q.waddr),
        .datas     (st_q.wdata),
        .addr_flat (commit_addr),
        .data_flat (commit_data)
    );

    always_comb begin
        logic     fire;
        logic     snoop_hit;
        logic     intf_now;
        logic     do_end;
        logic     ready_line;
        atm_end_e code;
        atm_op_e  op;

        st_d       = st_q;
        st_d.end_v    = 1'b0;
        st_d.commit_v = 1'b0;
        st_d.cmask    = '0;
        st_d.poll_v   = 1'b0;
        st_d.poll_flag = 1'b0;

        op         = atm_op_e'(req_op);
        fire       = req_valid && !st_q.pend;
        snoop_hit  = snoop_valid && st_q.active && snp_hit_raw;
        intf_now   = st_q.intf || snoop_hit;
        ready_line = lookup_hit && lookup_wperm;
        do_end     = 1'b0;
        code       = END_COMMIT;

        if (st_q.pend && miss_resp_valid) st_d.pend = 1'b0;
        if (snoop_hit) st_d.intf = 1'b1;

        if (fire) begin
            unique case (op)
                OP_BEGIN: begin
                    if (!st_q.active) begin
                        st_d.active = 1'b1;
                        st_d.wphase = 1'b0;
                        st_d.intf   = 1'b0;
                        st_d.rp     = req_addr;
                    end
                end
                OP_LDL, OP_PFL: begin
                    if (st_q.active) begin
                        if (st_q.wphase) begin
                            do_end = 1'b1;
                            code   = END_FAULT;
                        end else if (cam_hit) begin
                            if (!ready_line) begin
                                st_d.pend      = 1'b1;
                                st_d.pend_line = req_line;
                            end
                        end else if (st_q.cnt == CNT_W'(MAX_PART)) begin
                            do_end = 1'b1;
                            code   = END_FAULT;
                        end else begin
                            st_d.line[st_q.cnt[IDX_W-1:0]]  = req_line;
                            st_d.vmask[st_q.cnt[IDX_W-1:0]] = 1'b1;
                            st_d.cnt = st_q.cnt + 1'b1;
                            if (!ready_line) begin
                                st_d.pend      = 1'b1;
                                st_d.pend_line = req_line;
                            end
                        end
                    end
                end
                OP_ST, OP_STL: begin
                    if (st_q.active) begin
                        if (cam_hit) begin
                            st_d.dirty[cam_idx] = 1'b1;
                            st_d.waddr[cam_idx] = req_addr;
                            st_d.wdata[cam_idx] = req_wdata;
                            st_d.wphase = 1'b1;
                            if (op == OP_STL) begin
                                do_end = 1'b1;
                                if (intf_now) begin
                                    code       = END_RETRY;
                                    st_d.redir = st_q.rp;
                                end else begin
                                    code          = END_COMMIT;
                                    st_d.commit_v = 1'b1;
                                    st_d.cmask    = st_q.dirty | cam_match;
                                end
                            end
                        end else begin
                            do_end = 1'b1;
                            code   = END_FAULT;
                        end
                    end
                end
                OP_POLL: begin
                    if (st_q.active) begin
                        if (st_q.wphase) begin
                            do_end = 1'b1;
                            code   = END_FAULT;
                        end else begin
                            st_d.poll_v    = 1'b1;
                            st_d.poll_flag = intf_now;
                            if (intf_now) begin
                                do_end = 1'b1;
                                code   = END_POLLED;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end

        if (do_end) begin
            st_d.end_v    = 1'b1;
            st_d.end_code = code;
            st_d.active   = 1'b0;
            st_d.wphase   = 1'b0;
            st_d.intf     = 1'b0;
            st_d.pend     = 1'b0;
            st_d.cnt      = '0;
            st_d.vmask    = '0;
            st_d.dirty    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready      = !st_q.pend;
    assign miss_req_valid = st_q.pend;
    assign miss_req_line  = st_q.pend_line;
    assign evt_active     = st_q.active;
    assign intf_flag      = st_q.intf;
    assign poll_valid     = st_q.poll_v;
    assign poll_flag      = st_q.poll_flag;
    assign end_valid      = st_q.end_v;
    assign end_code       = st_q.end_code;
    assign redirect_pc    = st_q.redir;
    assign commit_valid   = st_q.commit_v;
    assign commit_mask    = st_q.cmask;

    // R3: slot count never passes the participant limit
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(MAX_PART));

    // R3: a line occupies at most one slot, so a request matches at most one slot
    p_cam_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cam_match));

    // R2: the occupied slots agree with the slot count
    p_vmask_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.vmask) == int'(st_q.cnt));

    // R6: no request is accepted while a fill is outstanding
    p_stall_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss_req_valid |-> !req_ready);

    // R6: the fill request stays up until it is answered
    p_fill_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_req_valid && !miss_resp_valid) |=> miss_req_valid);

    // R12: every end leaves the block empty
    p_clear_after_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        end_valid |-> (!evt_active && st_q.cnt == '0 && st_q.dirty == '0));

    // R9: a retry never exposes writes
    p_retry_no_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (end_valid && end_code == 2'd1) |-> !commit_valid);

    // R8: a commit always carries the final locked write
    p_commit_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (end_valid && end_code == 2'd0 && commit_mask != '0));

    // R13: nothing is held while idle
    p_idle_empty_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_active |-> (st_q.vmask == '0 && !intf_flag));
endmodule

// File: tb/atm_event_tracker_tb.sv
`timescale 1ns/1ps
module atm_event_tracker_tb;
    localparam int NP     = 8;
    localparam int AW     = 32;
    localparam int DW     = 32;
    localparam int LOFS   = 6;
    localparam int LW     = AW - LOFS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic lookup_hit = 1'b1, lookup_wperm = 1'b1;
    logic miss_req_valid;
    logic [LW-1:0] miss_req_line;
    logic miss_resp_valid = 1'b0;
    logic snoop_valid = 1'b0;
    logic [LW-1:0] snoop_line = '0;
    logic evt_active, intf_flag, poll_valid, poll_flag, end_valid, commit_valid;
    logic [1:0] end_code;
    logic [AW-1:0] redirect_pc;
    logic [NP-1:0] commit_mask;
    logic [NP*AW-1:0] commit_addr;
    logic [NP*DW-1:0] commit_data;

    always #2 clk = ~clk;

    atm_event_tracker #(.MAX_PART(NP), .ADDR_W(AW), .DATA_W(DW), .LINE_OFS(LOFS)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .lookup_hit(lookup_hit), .lookup_wperm(lookup_wperm),
        .miss_req_valid(miss_req_valid), .miss_req_line(miss_req_line),
        .miss_resp_valid(miss_resp_valid), .snoop_valid(snoop_valid), .snoop_line(snoop_line),
        .evt_active(evt_active), .intf_flag(intf_flag), .poll_valid(poll_valid),
        .poll_flag(poll_flag), .end_valid(end_valid), .end_code(end_code),
        .redirect_pc(redirect_pc), .commit_valid(commit_valid), .commit_mask(commit_mask),
        .commit_addr(commit_addr), .commit_data(commit_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    bit            m_active, m_wphase, m_intf;
    int            m_cnt;
    logic [AW-1:0] m_rp;
    logic [LW-1:0] m_line [NP];
    bit            m_dirty [NP];
    logic [AW-1:0] m_waddr [NP];
    logic [DW-1:0] m_wdata [NP];

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int m_find(logic [LW-1:0] ln);
        for (int i = 0; i < m_cnt; i++) if (m_line[i] == ln) return i;
        return -1;
    endfunction

    task automatic m_clear();
        m_active = 0; m_wphase = 0; m_intf = 0; m_cnt = 0;
        for (int i = 0; i < NP; i++) m_dirty[i] = 0;
    endtask

    function automatic logic [AW-1:0] mk_addr(int lp, int w);
        return AW'((32'h40 + lp) << LOFS) | AW'(w * 4);
    endfunction

    task automatic do_req(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d, bit hit, bit wp);
        bit e_end, e_commit, e_poll, e_pflag, e_miss;
        logic [1:0] e_code;
        logic [NP-1:0] e_mask;
        logic [NP*AW-1:0] e_addr;
        logic [NP*DW-1:0] e_data;
        logic [LW-1:0] ln;
        int ix;
        e_end = 0; e_commit = 0; e_poll = 0; e_pflag = 0; e_miss = 0;
        e_code = 0; e_mask = '0; e_addr = '0; e_data = '0;
        ln = a[AW-1:LOFS];
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
        lookup_hit = hit; lookup_wperm = wp;
        ix = m_find(ln);
        if (op == 3'd1) begin
            if (!m_active) begin m_clear(); m_active = 1; m_rp = a; end
        end else if (m_active) begin
            if (op == 3'd2 || op == 3'd3) begin
                if (m_wphase) begin e_end = 1; e_code = 2; end
                else if (ix >= 0) e_miss = !(hit && wp);
                else if (m_cnt == NP) begin e_end = 1; e_code = 2; end
                else begin m_line[m_cnt] = ln; m_cnt++; e_miss = !(hit && wp); end
            end else if (op == 3'd4 || op == 3'd5) begin
                if (ix < 0) begin e_end = 1; e_code = 2; end
                else begin
                    m_dirty[ix] = 1; m_waddr[ix] = a; m_wdata[ix] = d; m_wphase = 1;
                    if (op == 3'd5) begin
                        e_end = 1;
                        if (m_intf) e_code = 1;
                        else begin
                            e_commit = 1;
                            for (int i = 0; i < NP; i++) if (m_dirty[i]) begin
                                e_mask[i] = 1;
                                e_addr[i*AW +: AW] = m_waddr[i];
                                e_data[i*DW +: DW] = m_wdata[i];
                            end
                        end
                    end
                end
            end else if (op == 3'd6) begin
                if (m_wphase) begin e_end = 1; e_code = 2; end
                else begin
                    e_poll = 1; e_pflag = m_intf;
                    if (m_intf) begin e_end = 1; e_code = 3; end
                end
            end
        end
        @(negedge clk);
        req_valid = 0;
        chk("R4/R5/R8/R9/R11 end_valid", 256'(end_valid), 256'(e_end));
        if (e_end) chk("R4/R5/R8/R9/R11 end_code", 256'(end_code), 256'(e_code));
        chk("R7/R8 commit_valid", 256'(commit_valid), 256'(e_commit));
        if (e_commit) begin
            chk("R8 commit_mask", 256'(commit_mask), 256'(e_mask));
            chk("R8 commit_addr", 256'(commit_addr), 256'(e_addr));
            chk("R8 commit_data", 256'(commit_data), 256'(e_data));
        end
        if (e_end && e_code == 1) chk("R9 redirect_pc", 256'(redirect_pc), 256'(m_rp));
        chk("R11 poll_valid", 256'(poll_valid), 256'(e_poll));
        if (e_poll) chk("R11 poll_flag", 256'(poll_flag), 256'(e_pflag));
        if (e_end) m_clear();
        chk("R1/R12/R13 evt_active", 256'(evt_active), 256'(m_active));
        chk("R6 miss_req_valid", 256'(miss_req_valid), 256'(e_miss));
        if (e_miss) begin
            chk("R6 miss_req_line", 256'(miss_req_line), 256'(ln));
            chk("R6 req_ready low", 256'(req_ready), 256'(0));
            miss_resp_valid = 1;
            @(negedge clk);
            miss_resp_valid = 0;
            chk("R6 fill done", 256'({miss_req_valid, req_ready}), 256'(2'b01));
        end
    endtask

    task automatic do_snoop(logic [LW-1:0] ln);
        @(negedge clk);
        snoop_valid = 1; snoop_line = ln;
        if (m_active && m_find(ln) >= 0) m_intf = 1;
        @(negedge clk);
        snoop_valid = 0;
        chk("R9/R10 intf_flag", 256'(intf_flag), 256'(m_intf));
    endtask

    function automatic logic [LW-1:0] lof(int lp);
        return LW'(32'h40 + lp);
    endfunction

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs",
            256'({evt_active, end_valid, commit_valid, poll_valid, miss_req_valid, intf_flag, req_ready}),
            256'(7'b0000001));
        // R13 idle requests ignored, R10 idle snoop ignored
        do_req(3'd4, mk_addr(0, 1), 32'h11, 1, 1);
        do_req(3'd2, mk_addr(0, 0), 0, 1, 1);
        do_snoop(lof(0));
        // R1, R2, R6, R7, R8 basic commit
        do_req(3'd1, 32'h0000_1000, 0, 1, 1);
        do_req(3'd1, 32'h0000_2000, 0, 1, 1);          // R13 begin ignored while active
        do_req(3'd2, mk_addr(1, 0), 0, 1, 1);
        do_req(3'd3, mk_addr(2, 3), 0, 0, 0);          // R6 miss
        do_req(3'd2, mk_addr(3, 5), 0, 1, 0);          // R6 no write permission
        do_req(3'd2, mk_addr(1, 7), 0, 1, 1);          // R3 repeat touch
        do_snoop(lof(9));                              // R10 non-member snoop
        do_req(3'd4, mk_addr(1, 2), 32'hAAAA_0001, 1, 1);
        do_req(3'd4, mk_addr(1, 4), 32'hAAAA_0002, 1, 1); // R7 overwrite
        do_req(3'd5, mk_addr(3, 1), 32'hBBBB_0003, 1, 1); // R8 commit
        // R3, R4 ninth line fault; R12 then full reuse
        for (int k = 0; k < 2; k++) begin
            do_req(3'd1, 32'h0000_3000, 0, 1, 1);
            for (int i = 0; i < NP; i++) begin
                do_req(3'd2, mk_addr(i, 0), 0, 1, 1);
                do_req(3'd3, mk_addr(i, 1), 0, 1, 1);
            end
            do_req(3'd2, mk_addr(NP + k, 0), 0, 1, 1);
        end
        // R5 store to non-member, touch after store
        do_req(3'd1, 32'h0000_4000, 0, 1, 1);
        do_req(3'd2, mk_addr(0, 0), 0, 1, 1);
        do_req(3'd4, mk_addr(5, 0), 1, 1, 1);
        do_req(3'd1, 32'h0000_4000, 0, 1, 1);
        do_req(3'd2, mk_addr(0, 0), 0, 1, 1);
        do_req(3'd4, mk_addr(0, 0), 1, 1, 1);
        do_req(3'd2, mk_addr(1, 0), 0, 1, 1);
        // R9 retry
        do_req(3'd1, 32'h0000_5004, 0, 1, 1);
        do_req(3'd2, mk_addr(4, 0), 0, 1, 1);
        do_snoop(lof(4));
        do_req(3'd5, mk_addr(4, 0), 7, 1, 1);
        // R11 poll clear, poll set, poll after store
        do_req(3'd1, 32'h0000_6000, 0, 1, 1);
        do_req(3'd2, mk_addr(6, 0), 0, 1, 1);
        do_req(3'd6, 0, 0, 1, 1);
        do_snoop(lof(6));
        do_req(3'd6, 0, 0, 1, 1);
        do_req(3'd1, 32'h0000_6000, 0, 1, 1);
        do_req(3'd2, mk_addr(6, 0), 0, 1, 1);
        do_req(3'd4, mk_addr(6, 0), 3, 1, 1);
        do_req(3'd6, 0, 0, 1, 1);
        // constrained random
        void'($urandom(32'd2024));
        for (int n = 0; n < 4000; n++) begin
            int r, lp;
            r  = $urandom_range(0, 99);
            lp = $urandom_range(0, 11);
            if (!m_active) do_req(3'd1, 32'h8000 + 32'($urandom_range(0, 255)) * 4, 0, 1, 1);
            else if (r < 40) do_req(($urandom_range(0, 1) != 0) ? 3'd2 : 3'd3, mk_addr(lp, $urandom_range(0, 15)),
                                    0, $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0);
            else if (r < 65) do_req(3'd4, mk_addr(lp, $urandom_range(0, 15)), $urandom, 1, 1);
            else if (r < 75) do_req(3'd5, mk_addr(lp, $urandom_range(0, 15)), $urandom, 1, 1);
            else if (r < 80) do_req(3'd6, 0, 0, 1, 1);
            else if (r < 95) do_snoop(lof(lp));
            else do_req(3'd1, 32'h9000, 0, 1, 1);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule